// File: doc/BRIEF.md
# Trigger Phase Delay Unit

This block holds back a single-cycle trigger pulse for a programmable number of clock cycles and then emits it as a single-cycle pulse to the downstream re-trigger stage. Software sets the delay through a write port. A read word returns the delay setting and the live countdown value, so software can see how far an accepted trigger has progressed.

Only one trigger can be in flight. A trigger that arrives while a countdown is running is discarded, not queued or restarted, and it sets a sticky overflow flag. The flag stays set until a dedicated clear pulse. A delay setting of zero passes the trigger straight through in the same cycle, with no registered stage.

Top module: `trig_phase_delay`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_data` is 0, `ovf_flag` is 0 and `trig_out` stays low until a trigger is applied.
- R2: A cycle with `wr_en` high stores `wr_setting` as the delay setting. From the next cycle the setting reads back in `rd_data[15:0]`.
- R3: With a setting of 0, an accepted trigger shows on `trig_out` in the same cycle as `trig_in`, and `rd_data[31:16]` stays 0.
- R4: With a setting N from 1 to 65535, a trigger accepted in cycle t gives exactly one `trig_out` pulse, in cycle t+N.
- R5: After an accepted trigger with setting N > 0, `rd_data[31:16]` reads N in the following cycle and then falls by 1 on every clock until it reaches 0.
- R6: A trigger that arrives while `rd_data[31:16]` is nonzero produces no output pulse of its own and does not change the countdown. It sets `ovf_flag` from the next cycle.
- R7: A trigger that arrives in the cycle where the countdown reads 1 is dropped, even though the pending pulse leaves in that cycle. It sets `ovf_flag`.
- R8: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. If a clear and a new overflow fall in the same cycle, the flag stays set.
- R9: A write to the setting during a countdown does not change that countdown or its pulse time. The new value applies from the next accepted trigger.
- R10: With a setting of 0, triggers in back-to-back cycles are each passed through and none of them sets `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| trig_in | input | 1 | Single-cycle trigger request |
| wr_en | input | 1 | Write strobe for the delay setting |
| wr_setting | input | 16 | Delay setting to store |
| ovf_clr | input | 1 | Clears the overflow flag |
| trig_out | output | 1 | Delayed single-cycle trigger |
| rd_data | output | 32 | Status word: countdown in [31:16], setting in [15:0] |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two things can happen in the same cycle here. The last countdown step forwards its pulse while a fresh trigger arrives, and a software clear meets a new overflow. The bench sets up both on purpose: it times a second trigger into the cycle where the status reads 1, and it raises `ovf_clr` together with a busy trigger. It then checks that no extra pulse appears, that the countdown still reaches 0, and that the flag stays set. Random stimulus with short delays makes these collisions frequent, and a cycle model built from the requirements judges every cycle.

// File: rtl/tpd_pkg.sv
package tpd_pkg;
  localparam int unsigned TPD_CNT_W_DEF = 16;

  function automatic logic is_zero16(input logic [TPD_CNT_W_DEF-1:0] v);
    return (v == '0);
  endfunction
endpackage

// File: rtl/tpd_cfg_reg.sv
module tpd_cfg_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cfg_q
);
  logic [W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q == $past(wr_val));
endmodule

// File: rtl/tpd_countdown.sv
module tpd_countdown #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_in,
  input  logic [W-1:0] cfg,
  output logic [W-1:0] cnt_q,
  output logic         busy,
  output logic         fwd
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic         load;

  assign busy = (cnt_q != '0);
  assign fwd  = (cnt_q == ONE);
  assign load = trig_in && !busy && (cfg != '0);

  always_comb begin
    cnt_en = busy | load;
    cnt_d  = cnt_q;
    if (busy)      cnt_d = cnt_q - ONE;
    else if (load) cnt_d = cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && cnt_q == '0 && cfg != '0) |=> cnt_q == $past(cfg));
  assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  assert_last_step_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && cnt_q == ONE) |=> cnt_q == '0);
endmodule

// File: rtl/tpd_ovf_flag.sv
module tpd_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set | clr;
    flag_d  = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/trig_phase_delay.sv
module trig_phase_delay #(
  parameter int unsigned CNT_W = tpd_pkg::TPD_CNT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_in,
  input  logic               wr_en,
  input  logic [CNT_W-1:0]   wr_setting,
  input  logic               ovf_clr,
  output logic               trig_out,
  output logic [2*CNT_W-1:0] rd_data,
  output logic               ovf_flag
);
  localparam int unsigned REG_W = 2 * CNT_W;

  logic [CNT_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy;
  logic             fwd;
  logic             drop;
  logic             pass_now;

  tpd_cfg_reg #(.W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_setting), .cfg_q(cfg_q)
  );

  tpd_countdown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cfg(cfg_q),
    .cnt_q(cnt_q), .busy(busy), .fwd(fwd)
  );

  assign drop     = trig_in & busy;
  assign pass_now = trig_in & ~busy & (cfg_q == '0);

  tpd_ovf_flag u_ovf (
    .clk(clk), .rst_n(rst_n), .set(drop), .clr(ovf_clr), .flag_q(ovf_flag)
  );

  assign trig_out = fwd | pass_now;
  assign rd_data  = {cnt_q, cfg_q};

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && rd_data[REG_W-1:CNT_W] == '0 && rd_data[CNT_W-1:0] == '0) |-> trig_out);
  assert_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == '0 && !wr_en) |=> rd_data[REG_W-1:CNT_W] == '0);
  assert_no_pulse_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_in && rd_data[REG_W-1:CNT_W] == '0) |-> !trig_out);
endmodule

// File: tb/tb_trig_phase_delay.sv
module tb_trig_phase_delay;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          trig_in, wr_en, ovf_clr;
  logic [W-1:0]  wr_setting;
  logic          trig_out, ovf_flag;
  logic [2*W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [W-1:0] m_cfg, m_cnt;
  logic         m_ovf;

  always #2 clk = ~clk;

  trig_phase_delay #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .wr_en(wr_en),
    .wr_setting(wr_setting), .ovf_clr(ovf_clr), .trig_out(trig_out),
    .rd_data(rd_data), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_out(input logic t);
    return (m_cnt == 16'd1) || (t && m_cnt == '0 && m_cfg == '0);
  endfunction

  // One clock: drive inputs after the falling edge, check before the rising edge, then step the model.
  task automatic cyc(input logic t, input logic w, input logic [W-1:0] d, input logic c,
                     input string tag);
    logic busy;
    trig_in = t; wr_en = w; wr_setting = d; ovf_clr = c;
    #1;
    chk((tag != "") ? tag : ((m_cfg == '0 && m_cnt == '0) ? "R3" : "R4"),
        {31'd0, trig_out}, {31'd0, exp_out(t)});
    chk((tag != "") ? tag : "R5", {16'd0, rd_data[31:16]}, {16'd0, m_cnt});
    chk((tag != "") ? tag : "R2", {16'd0, rd_data[15:0]}, {16'd0, m_cfg});
    chk((tag != "") ? tag : "R8", {31'd0, ovf_flag}, {31'd0, m_ovf});
    @(posedge clk);
    busy  = (m_cnt != '0);
    m_ovf = (t && busy) | (m_ovf & ~c);
    if (busy)                  m_cnt = m_cnt - 16'd1;
    else if (t && m_cfg != '0) m_cnt = m_cfg;
    if (w) m_cfg = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b0, tag);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; trig_in = 0; wr_en = 0; ovf_clr = 0; wr_setting = '0;
    m_cfg = '0; m_cnt = '0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", rd_data, 32'd0);
    chk("R1", {31'd0, ovf_flag}, 32'd0);
    chk("R1", {31'd0, trig_out}, 32'd0);
    rst_n = 1'b1;
    idle(2, "R1");

    // R2: write and read back
    cyc(0, 1, 16'h0005, 0, "R2");
    idle(1, "R2");
    // R3 and R10: zero setting, back-to-back triggers
    cyc(0, 1, 16'h0000, 0, "R3");
    cyc(1, 0, '0, 0, "R3");
    cyc(1, 0, '0, 0, "R10");
    cyc(1, 0, '0, 0, "R10");
    idle(1, "R10");
    // R4/R5: setting 5
    cyc(0, 1, 16'd5, 0, "R2");
    cyc(1, 0, '0, 0, "R4");
    idle(6, "R5");
    // R6: trigger mid-count
    cyc(1, 0, '0, 0, "R4");
    idle(2, "R6");
    cyc(1, 0, '0, 0, "R6");
    idle(4, "R6");
    // R8: clear, then clear together with a new overflow
    cyc(0, 0, '0, 1, "R8");
    cyc(1, 0, '0, 0, "R8");
    cyc(1, 0, '0, 1, "R8");
    idle(6, "R8");
    cyc(0, 0, '0, 1, "R8");
    idle(1, "R8");
    // R7: trigger on the last step
    cyc(0, 1, 16'd3, 0, "R7");
    cyc(1, 0, '0, 0, "R7");
    idle(2, "R7");
    cyc(1, 0, '0, 0, "R7");
    idle(4, "R7");
    cyc(0, 0, '0, 1, "R7");
    // R9: write during a countdown
    cyc(1, 0, '0, 0, "R9");
    cyc(0, 1, 16'd7, 0, "R9");
    idle(4, "R9");
    cyc(1, 0, '0, 0, "R9");
    idle(9, "R9");
    // large setting at the top of the range
    cyc(0, 1, 16'hFFFF, 0, "R2");
    cyc(1, 0, '0, 0, "R4");
    idle(65536, "");
    // random traffic with short delays
    for (int i = 0; i < 3000; i++) begin
      logic t, w, c;
      t = ($urandom_range(0, 99) < 35);
      w = ($urandom_range(0, 99) < 6);
      c = ($urandom_range(0, 99) < 8);
      cyc(t, w, W'($urandom_range(0, 6)), c, "");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule